// File: doc/BRIEF.md
# Calendar Real-Time Clock with Crystal Trim

This block keeps wall-clock time from a 32.768 kHz reference. The reference arrives as a one-cycle strobe, `ref_tick`, in the system clock domain. A sub-second divider turns these strobes into seconds. Separate binary counters then hold second, minute, hour, day, month and a two-digit year. Month lengths and February in leap years are handled by the counters themselves, so software only has to load the time once.

Crystal error is corrected by a signed 11-bit trim. The trim is counted in steps of 1/2^21, which is close to 0.48 ppm, and covers roughly ±488 ppm. Over every 2^21-strobe window (64 s at the nominal rate), the block adds or removes that many strobes. A phase accumulator spreads these corrections evenly across the window, and they are applied before the divider.

The block raises three periodic interrupt pulses: every half second, every second and every minute. Each pulse has its own enable bit. Software reaches the time, the trim and the enables through a plain address, data and write-enable port. Reads are combinational.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields hold: second 0, minute 0, hour 0, day 1, month 1, year 0. The trim is 0, all interrupt enables are 0 and all interrupt outputs are low.
- R2: The register map, with time fields in binary:
  - addr 0 = second (0..59)
  - addr 1 = minute (0..59)
  - addr 2 = hour (0..23)
  - addr 3 = day (1..31)
  - addr 4 = month (1..12)
  - addr 5 = year (0..99)
  - addr 6 = trim bits [7:0]
  - addr 7 = trim bits [10:8] in data bits [2:0], with enables in data bits [4] (half second), [5] (second) and [6] (minute)

  `rd_data` returns the addressed field. A write whose value is outside the field's range leaves the field unchanged.
- R3: With trim 0, the second advances once per 2^DIV_W strobes. Any write to addresses 0..5 clears the sub-second divider and the trim accumulator, so a full second follows the write. A strobe in a write cycle is dropped.
- R4: Second 59 wraps to 0 and carries into the minute. Minute 59 wraps and carries into the hour. Hour 23 wraps to 0 and carries into the day.
- R5: The day wraps to 1 after 30 in April, June, September and November, and after 31 in the other months except February. Month 12 wraps to 1.
- R6: February ends on day 29 when year mod 4 is 0 (year 0 included), otherwise on day 28.
- R7: Year 99 wraps to 0 at the end of 31 December.
- R8: A positive trim T makes the divider count one extra strobe T times per 2^WIN_W strobes.
- R9: A negative trim (two's complement) drops |T| strobes per 2^WIN_W strobes.
- R10: Trim corrections are spread evenly. Starting from a cleared accumulator, the first k strobes carry floor(k·|T|/2^WIN_W) corrections.
- R11: Each interrupt is a registered single-cycle pulse.
  - The half-second pulse fires at each half-divider crossing.
  - The second pulse fires when the second advances.
  - The minute pulse fires when the second wraps to 0.
- R12: A pulse appears only while its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| irq_half | output | 1 | Half-second interrupt pulse |
| irq_sec | output | 1 | One-second interrupt pulse |
| irq_min | output | 1 | One-minute interrupt pulse |

## Verification
The bench loads end-of-day times into 30-day months, 31-day months, and February in leap and common years. It also starts one day at the end of year 99. A wrong month table or leap test would show up as a day 31 or 29 that should not exist, or as a missing day 29. Trim is checked by counting whole seconds over a full window and over half a window, with positive and negative values. Dropped or doubled corrections, or corrections bunched at the end of the window, then show as the wrong seconds count. An interrupt scoreboard catches pulses that are not gated by their enables, a missing half-second pulse when it coincides with the second, and a minute pulse on the wrong second.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int DIV_W = 15,
  parameter int WIN_W = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq_half,
  output logic       irq_sec,
  output logic       irq_min
);
  localparam int TRIM_W = 11;

  logic [DIV_W-1:0]  pre_q;
  logic [WIN_W-1:0]  acc_q;
  logic [5:0]        sec_q, min_q;
  logic [4:0]        hour_q, day_q;
  logic [3:0]        mon_q;
  logic [6:0]        year_q;
  logic [TRIM_W-1:0] trim_q;
  logic [2:0]        ien_q;

  logic [TRIM_W-1:0] trim_mag;
  logic [WIN_W:0]    acc_sum;
  logic              adj;
  logic [1:0]        step;
  logic [DIV_W:0]    pre_sum;
  logic              tick_ok, sec_evt, half_evt, min_evt, time_wr;
  logic [4:0]        dim;

  assign trim_mag = trim_q[TRIM_W-1] ? (~trim_q + 1'b1) : trim_q;
  assign acc_sum  = {1'b0, acc_q} + (WIN_W+1)'(trim_mag);
  assign adj      = acc_sum[WIN_W];
  assign step     = !adj ? 2'd1 : (trim_q[TRIM_W-1] ? 2'd0 : 2'd2);
  assign pre_sum  = {1'b0, pre_q} + {{(DIV_W-1){1'b0}}, step};
  assign tick_ok  = ref_tick && !wr_en;
  assign sec_evt  = tick_ok && pre_sum[DIV_W];
  assign half_evt = tick_ok && (pre_q[DIV_W-1] != pre_sum[DIV_W-1]);
  assign min_evt  = sec_evt && (sec_q == 6'd59);
  assign time_wr  = wr_en && (addr <= 3'd5);

  always_comb begin
    case (mon_q)
      4'd4, 4'd6, 4'd9, 4'd11: dim = 5'd30;
      4'd2:                    dim = (year_q[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 dim = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      acc_q <= '0;
    end else if (time_wr) begin
      pre_q <= '0;
      acc_q <= '0;
    end else if (tick_ok) begin
      pre_q <= pre_sum[DIV_W-1:0];
      acc_q <= acc_sum[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= 5'd1;
      mon_q  <= 4'd1;
      year_q <= '0;
      trim_q <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: if (wr_data < 8'd60) sec_q <= wr_data[5:0];
        3'd1: if (wr_data < 8'd60) min_q <= wr_data[5:0];
        3'd2: if (wr_data < 8'd24) hour_q <= wr_data[4:0];
        3'd3: if (wr_data >= 8'd1 && wr_data <= 8'd31) day_q <= wr_data[4:0];
        3'd4: if (wr_data >= 8'd1 && wr_data <= 8'd12) mon_q <= wr_data[3:0];
        3'd5: if (wr_data < 8'd100) year_q <= wr_data[6:0];
        3'd6: trim_q[7:0] <= wr_data;
        default: begin
          trim_q[10:8] <= wr_data[2:0];
          ien_q        <= wr_data[6:4];
        end
      endcase
    end else if (sec_evt) begin
      if (sec_q != 6'd59) sec_q <= sec_q + 6'd1;
      else begin
        sec_q <= '0;
        if (min_q != 6'd59) min_q <= min_q + 6'd1;
        else begin
          min_q <= '0;
          if (hour_q != 5'd23) hour_q <= hour_q + 5'd1;
          else begin
            hour_q <= '0;
            if (day_q < dim) day_q <= day_q + 5'd1;
            else begin
              day_q <= 5'd1;
              if (mon_q != 4'd12) mon_q <= mon_q + 4'd1;
              else begin
                mon_q  <= 4'd1;
                year_q <= (year_q == 7'd99) ? 7'd0 : year_q + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_half <= 1'b0;
      irq_sec  <= 1'b0;
      irq_min  <= 1'b0;
    end else begin
      irq_half <= half_evt && ien_q[0];
      irq_sec  <= sec_evt && ien_q[1];
      irq_min  <= min_evt && ien_q[2];
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = {2'b0, sec_q};
      3'd1:    rd_data = {2'b0, min_q};
      3'd2:    rd_data = {3'b0, hour_q};
      3'd3:    rd_data = {3'b0, day_q};
      3'd4:    rd_data = {4'b0, mon_q};
      3'd5:    rd_data = {1'b0, year_q};
      3'd6:    rd_data = trim_q[7:0];
      default: rd_data = {1'b0, ien_q, 1'b0, trim_q[10:8]};
    endcase
  end

  a_r4_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q < 6'd60);
  a_r5_day_range: assert property (@(posedge clk) disable iff (!rst_n)
    (day_q >= 5'd1) && (day_q <= 5'd31));
  a_r5_month_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q >= 4'd1) && (mon_q <= 4'd12));
  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 6'd1) ||
               (sec_q == 6'd0 && $past(sec_q) == 6'd59));
  a_r11_half_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half |=> !irq_half);
  a_r11_sec_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sec |=> !irq_sec);
  a_r11_min_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    irq_min |-> sec_q == 6'd0);
endmodule

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_half, irq_sec, irq_min;

  int n_chk = 0;
  int n_err = 0;
  logic [2:0] exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar #(.DIV_W(4), .WIN_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_half(irq_half), .irq_sec(irq_sec), .irq_min(irq_min));

  always @(negedge clk) begin
    if (rst_n && {irq_min, irq_sec, irq_half} != 3'b000) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R11/R12: unexpected pulse got %b expected none", {irq_min, irq_sec, irq_half});
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        if (e != {irq_min, irq_sec, irq_half}) begin
          n_err++;
          $display("FAIL R11/R12: pulse got %b expected %b", {irq_min, irq_sec, irq_half}, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    n_chk++;
    if (rd_data !== e) begin
      n_err++;
      $display("FAIL %s: addr %0d got %0d expected %0d", tag, a, rd_data, e);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic set_time(input int s, input int m, input int h, input int d, input int mo, input int y);
    wr(3'd0, 8'(s)); wr(3'd1, 8'(m)); wr(3'd2, 8'(h));
    wr(3'd3, 8'(d)); wr(3'd4, 8'(mo)); wr(3'd5, 8'(y));
  endtask

  task automatic chk_date(input int s, input int m, input int h, input int d, input int mo, input int y, input string tag);
    rd_chk(3'd0, 8'(s), tag); rd_chk(3'd1, 8'(m), tag); rd_chk(3'd2, 8'(h), tag);
    rd_chk(3'd3, 8'(d), tag); rd_chk(3'd4, 8'(mo), tag); rd_chk(3'd5, 8'(y), tag);
  endtask

  task automatic chk_empty(input string tag);
    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL %s: missing pulses got %0d left expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run hung got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_date(0, 0, 0, 1, 1, 0, "R1");
    rd_chk(3'd6, 8'h00, "R1");
    rd_chk(3'd7, 8'h00, "R1");
    n_chk++;
    if ({irq_min, irq_sec, irq_half} != 3'b000) begin
      n_err++;
      $display("FAIL R1: irq got %b expected 000", {irq_min, irq_sec, irq_half});
    end

    // R2 readback and out-of-range writes ignored
    wr(3'd1, 8'd45);  rd_chk(3'd1, 8'd45, "R2");
    wr(3'd0, 8'd60);  rd_chk(3'd0, 8'd0, "R2");
    wr(3'd4, 8'd13);  rd_chk(3'd4, 8'd1, "R2");
    wr(3'd3, 8'd0);   rd_chk(3'd3, 8'd1, "R2");
    wr(3'd2, 8'd24);  rd_chk(3'd2, 8'd0, "R2");
    wr(3'd6, 8'h5A);  rd_chk(3'd6, 8'h5A, "R2");
    wr(3'd6, 8'h00);

    // R3 divider and clear on time write
    set_time(0, 0, 0, 1, 1, 0);
    ticks(15); rd_chk(3'd0, 8'd0, "R3");
    ticks(1);  rd_chk(3'd0, 8'd1, "R3");
    ticks(8);  wr(3'd1, 8'd0);
    ticks(15); rd_chk(3'd0, 8'd1, "R3");
    ticks(1);  rd_chk(3'd0, 8'd2, "R3");

    // R4 time rollover
    set_time(59, 59, 23, 10, 5, 30); ticks(16);
    chk_date(0, 0, 0, 11, 5, 30, "R4");
    set_time(59, 12, 7, 10, 5, 30); ticks(16);
    chk_date(0, 13, 7, 10, 5, 30, "R4");

    // R5 month lengths
    set_time(59, 59, 23, 30, 4, 30); ticks(16); chk_date(0, 0, 0, 1, 5, 30, "R5");
    set_time(59, 59, 23, 30, 1, 30); ticks(16); chk_date(0, 0, 0, 31, 1, 30, "R5");
    set_time(59, 59, 23, 31, 1, 30); ticks(16); chk_date(0, 0, 0, 1, 2, 30, "R5");
    set_time(59, 59, 23, 28, 2, 23); ticks(16); chk_date(0, 0, 0, 1, 3, 23, "R5");

    // R6 leap years
    set_time(59, 59, 23, 28, 2, 24); ticks(16); chk_date(0, 0, 0, 29, 2, 24, "R6");
    set_time(59, 59, 23, 29, 2, 24); ticks(16); chk_date(0, 0, 0, 1, 3, 24, "R6");
    set_time(59, 59, 23, 28, 2, 0);  ticks(16); chk_date(0, 0, 0, 29, 2, 0, "R6");

    // R7 century wrap
    set_time(59, 59, 23, 31, 12, 99); ticks(16); chk_date(0, 0, 0, 1, 1, 0, "R7");

    // R8 positive trim +32 over 256-tick window: 288 counts = 18 s
    wr(3'd6, 8'd32); wr(3'd7, 8'h00);
    set_time(0, 0, 0, 1, 1, 0); ticks(256);
    rd_chk(3'd0, 8'd18, "R8");
    // R10 half window: 16 corrections, 144 counts = 9 s
    set_time(0, 0, 0, 1, 1, 0); ticks(128);
    rd_chk(3'd0, 8'd9, "R10");
    set_time(0, 0, 0, 1, 1, 0); ticks(64);
    rd_chk(3'd0, 8'd4, "R10");

    // R9 negative trim -32 (0x7E0): 224 counts = 14 s
    wr(3'd6, 8'hE0); wr(3'd7, 8'h07);
    rd_chk(3'd7, 8'h07, "R9");
    set_time(0, 0, 0, 1, 1, 0); ticks(256);
    rd_chk(3'd0, 8'd14, "R9");
    wr(3'd6, 8'h00); wr(3'd7, 8'h00);

    // R11 interrupts, all enabled; bits {min,sec,half}
    wr(3'd7, 8'h70);
    set_time(58, 0, 0, 1, 1, 0);
    exp_q.push_back(3'b001); exp_q.push_back(3'b011);
    exp_q.push_back(3'b001); exp_q.push_back(3'b111);
    ticks(32);
    chk_empty("R11");

    // R12 half-second disabled
    wr(3'd7, 8'h60);
    set_time(58, 0, 0, 1, 1, 0);
    exp_q.push_back(3'b010); exp_q.push_back(3'b110);
    ticks(32);
    chk_empty("R12");

    // R12 all disabled: monitor flags any pulse
    wr(3'd7, 8'h00);
    set_time(58, 0, 0, 1, 1, 0);
    ticks(32);
    chk_empty("R12");
    rd_chk(3'd1, 8'd1, "R12");

    done = 1'b1;
    finish_run();
  end
endmodule